// File: doc/BRIEF.md
# Fuse Word Burn Sequencer with Read-Back Verification

This block writes one data word into a one-time-programmable fuse array through a separate fuse controller. Fuse cells can only go from 0 to 1, and a single program pulse does not always take. The sequencer first reads the target word. It then programs only the bits that the requested value needs and that are still 0. After every program command it reads the word back and removes from its pending set every bit that now reads as 1. It stops with success when nothing is pending. It stops with failure when the attempt budget is spent and bits are still missing.

Software or a boot engine pulses a start input with an address and a value, then waits for a one-cycle completion pulse that carries the pass/fail status. Every access to the array goes through a request/done handshake on the controller side. All read-backs are real read commands to the array, so a freshly burned bit is seen as soon as it takes.

Top module: `fuse_burn_seq`

## Requirements
- R1: After reset `busy_o`, `done_o` and `ctl_req_o` are low, and `ctl_req_o` stays low whenever `busy_o` is low.
- R2: A `start_i` pulse while idle captures `addr_i` and `value_i`. The first controller command of the operation is a read (`ctl_write_o`=0) at the captured address, and every command of the operation uses that address.
- R3: The initial pending set is the captured value ANDed with the inverse of the word returned by the first read. If it is zero, the operation completes with pass and issues no program command.
- R4: Every program command (`ctl_write_o`=1) carries the current pending set as `ctl_wdata_o`. That set never contains a bit outside the requested value and never contains a bit that the array already holds as 1.
- R5: Every program command is followed by a read of the same address. Each bit returned as 1 is removed from the pending set, so an operation issues exactly one more read than program commands.
- R6: When a verification read leaves the pending set empty, the operation completes with `pass_o`=1, and the array word equals the old word ORed with the requested value.
- R7: An attempt counter is incremented after each verification read. When it exceeds MAX_RETRY (default 3) with bits still pending, the operation completes with `pass_o`=0 after exactly MAX_RETRY+1 program commands.
- R8: `done_o` is high for exactly one cycle per operation, `pass_o` is meaningful only in that cycle, and `busy_o` is low in the cycle after it.
- R9: A `start_i` pulse while `busy_o` is high is ignored. No extra completion occurs and the address given with it is never accessed.
- R10: `ctl_req_o` stays high, with `ctl_write_o`, `ctl_addr_o` and `ctl_wdata_o` unchanged, from the cycle a command is issued until the cycle in which `ctl_done_i` is high. A new command may follow in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse for one burn operation |
| addr_i | input | AW | Fuse word address, captured at start |
| value_i | input | DW | Value whose 1 bits must end up set, captured at start |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Outcome, valid while done_o is high |
| ctl_req_o | output | 1 | Command request to the fuse controller |
| ctl_write_o | output | 1 | 1 = program command, 0 = array read |
| ctl_addr_o | output | AW | Command address |
| ctl_wdata_o | output | DW | Bits to program |
| ctl_done_i | input | 1 | Command complete (one cycle) |
| ctl_rdata_i | input | DW | Read data, valid with ctl_done_i |

## Verification
The bench's fuse model can refuse a given number of program pulses, and it can hold individual bits that never burn. This lets it reach both edges of the retry budget: success on the last allowed attempt and failure one attempt later. A design with an off-by-one counter shows up as a wrong program count or a wrong outcome. Re-burning a word that is already set checks the empty-mask shortcut, since a design without it would issue a needless program command. A partially set word shows whether a design reprograms bits that are already 1. A second start pulse mid-operation, aimed at a different word, shows whether the design lets a new request break into a busy sequence: that word would be written or an extra completion pulse would appear.

// File: rtl/fuse_burn_pkg.sv
package fuse_burn_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ_INIT,
      ST_PROGRAM,
      ST_VERIFY_READ,
      ST_DONE_OK,
      ST_DONE_FAIL
   } seq_state_e;
endpackage

// File: rtl/fuse_burn_mask.sv
// Holds the captured request value and the set of bits still to be burned.
module fuse_burn_mask #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          capture_i,
   input  logic [DW-1:0] value_i,
   input  logic          load_i,
   input  logic          update_i,
   input  logic [DW-1:0] rdata_i,
   output logic [DW-1:0] value_o,
   output logic [DW-1:0] mask_o,
   output logic          next_zero_o
);
   logic [DW-1:0] value_q;
   logic [DW-1:0] mask_q;
   logic [DW-1:0] mask_next;

   // Initial set comes from the request, later sets shrink from the pending one.
   always_comb begin
      if (load_i) mask_next = value_q & ~rdata_i;
      else        mask_next = mask_q  & ~rdata_i;
   end

   assign next_zero_o = (mask_next == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         value_q <= '0;
         mask_q  <= '0;
      end else if (capture_i) begin
         value_q <= value_i;
         mask_q  <= '0;
      end else if (load_i || update_i) begin
         mask_q  <= mask_next;
      end
   end

   assign value_o = value_q;
   assign mask_o  = mask_q;
endmodule

// File: rtl/fuse_burn_tries.sv
// Counts verification reads and flags the one that exhausts the budget.
module fuse_burn_tries #(
   parameter int MAX_RETRY = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic inc_i,
   output logic last_o
);
   localparam int CW = $clog2(MAX_RETRY + 2);
   localparam logic [CW-1:0] LIMIT = CW'(MAX_RETRY);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (clear_i)                cnt_q <= '0;
      else if (inc_i && cnt_q <= LIMIT) cnt_q <= cnt_q + 1'b1;
   end

   // Incrementing from LIMIT makes the count exceed the budget.
   generate
      if (MAX_RETRY == 0) begin : g_single
         assign last_o = 1'b1;
      end else begin : g_multi
         assign last_o = (cnt_q >= LIMIT);
      end
   endgenerate
endmodule

// File: rtl/fuse_burn_fsm.sv
// Sequencing of read, program and verify commands.
module fuse_burn_fsm
   import fuse_burn_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       ctl_done_i,
   input  logic       next_zero_i,
   input  logic       last_i,
   output seq_state_e state_o,
   output logic       capture_o,
   output logic       load_o,
   output logic       update_o
);
   seq_state_e state_q, state_d;

   assign capture_o = (state_q == ST_IDLE) && start_i;
   assign load_o    = (state_q == ST_READ_INIT) && ctl_done_i;
   assign update_o  = (state_q == ST_VERIFY_READ) && ctl_done_i;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:        if (start_i) state_d = ST_READ_INIT;
         ST_READ_INIT:   if (ctl_done_i) state_d = next_zero_i ? ST_DONE_OK : ST_PROGRAM;
         ST_PROGRAM:     if (ctl_done_i) state_d = ST_VERIFY_READ;
         ST_VERIFY_READ: begin
            if (ctl_done_i) begin
               if (next_zero_i) state_d = ST_DONE_OK;
               else if (last_i) state_d = ST_DONE_FAIL;
               else             state_d = ST_PROGRAM;
            end
         end
         ST_DONE_OK,
         ST_DONE_FAIL:   state_d = ST_IDLE;
         default:        state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign state_o = state_q;
endmodule

// File: rtl/fuse_burn_seq.sv
module fuse_burn_seq
   import fuse_burn_pkg::*;
#(
   parameter int DW        = 32,
   parameter int AW        = 8,
   parameter int MAX_RETRY = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] value_i,
   output logic          busy_o,
   output logic          done_o,
   output logic          pass_o,
   output logic          ctl_req_o,
   output logic          ctl_write_o,
   output logic [AW-1:0] ctl_addr_o,
   output logic [DW-1:0] ctl_wdata_o,
   input  logic          ctl_done_i,
   input  logic [DW-1:0] ctl_rdata_i
);
   generate
      if (DW < 1) begin : g_bad_dw
         $error("fuse_burn_seq: DW must be at least 1");
      end
      if (AW < 1) begin : g_bad_aw
         $error("fuse_burn_seq: AW must be at least 1");
      end
      if (MAX_RETRY < 0) begin : g_bad_retry
         $error("fuse_burn_seq: MAX_RETRY must not be negative");
      end
   endgenerate

   seq_state_e    state;
   logic          capture, load, update, next_zero, last;
   logic [DW-1:0] value_q;
   logic [DW-1:0] mask;
   logic [AW-1:0] addr_q;

   fuse_burn_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .ctl_done_i  (ctl_done_i),
      .next_zero_i (next_zero),
      .last_i      (last),
      .state_o     (state),
      .capture_o   (capture),
      .load_o      (load),
      .update_o    (update)
   );

   fuse_burn_mask #(.DW(DW)) u_mask (
      .clk         (clk),
      .rst_n       (rst_n),
      .capture_i   (capture),
      .value_i     (value_i),
      .load_i      (load),
      .update_i    (update),
      .rdata_i     (ctl_rdata_i),
      .value_o     (value_q),
      .mask_o      (mask),
      .next_zero_o (next_zero)
   );

   fuse_burn_tries #(.MAX_RETRY(MAX_RETRY)) u_tries (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (capture),
      .inc_i   (update),
      .last_o  (last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)       addr_q <= '0;
      else if (capture) addr_q <= addr_i;
   end

   assign busy_o      = (state != ST_IDLE);
   assign done_o      = (state == ST_DONE_OK) || (state == ST_DONE_FAIL);
   assign pass_o      = (state == ST_DONE_OK);
   assign ctl_req_o   = (state == ST_READ_INIT) || (state == ST_PROGRAM) ||
                        (state == ST_VERIFY_READ);
   assign ctl_write_o = (state == ST_PROGRAM);
   assign ctl_addr_o  = addr_q;
   assign ctl_wdata_o = (state == ST_PROGRAM) ? mask : '0;
endmodule

// File: rtl/fuse_burn_chk.sv
module fuse_burn_chk #(
   parameter int DW        = 32,
   parameter int AW        = 8,
   parameter int MAX_RETRY = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic          busy_o,
   input logic          done_o,
   input logic          pass_o,
   input logic          ctl_req_o,
   input logic          ctl_write_o,
   input logic [AW-1:0] ctl_addr_o,
   input logic [DW-1:0] ctl_wdata_o,
   input logic          ctl_done_i,
   input logic [DW-1:0] value_q
);
   localparam int PCW = $clog2(MAX_RETRY + 3) + 1;
   logic [PCW-1:0] prog_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !busy_o)                      prog_cnt <= '0;
      else if (ctl_req_o && ctl_write_o && ctl_done_i) prog_cnt <= prog_cnt + 1'b1;
   end

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !ctl_req_o);

   p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> $stable(ctl_addr_o));

   p_prog_subset_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_req_o && ctl_write_o) |-> ((ctl_wdata_o & ~value_q) == '0 && ctl_wdata_o != '0));

   p_prog_then_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_req_o && ctl_write_o && ctl_done_i) |=> (ctl_req_o && !ctl_write_o));

   p_prog_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (prog_cnt <= PCW'(MAX_RETRY + 1)));

   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && !busy_o));

   p_pass_in_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pass_o |-> done_o);

   p_cmd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_req_o && !ctl_done_i) |=>
         (ctl_req_o && $stable(ctl_write_o) && $stable(ctl_addr_o) && $stable(ctl_wdata_o)));
endmodule

bind fuse_burn_seq fuse_burn_chk #(.DW(DW), .AW(AW), .MAX_RETRY(MAX_RETRY)) u_chk (.*);

// File: tb/sim_fuse_burn_seq.sv
module sim_fuse_burn_seq;
   localparam int DW = 32;
   localparam int AW = 8;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] addr  = '0;
   logic [DW-1:0] value = '0;
   logic          busy, done, pass, req, wr;
   logic [AW-1:0] caddr;
   logic [DW-1:0] wdata;
   logic          cdone = 1'b0;
   logic [DW-1:0] rdata = '0;

   fuse_burn_seq #(.DW(DW), .AW(AW), .MAX_RETRY(3)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr), .value_i(value),
      .busy_o(busy), .done_o(done), .pass_o(pass),
      .ctl_req_o(req), .ctl_write_o(wr), .ctl_addr_o(caddr), .ctl_wdata_o(wdata),
      .ctl_done_i(cdone), .ctl_rdata_i(rdata)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   // Fuse array and controller model
   logic [DW-1:0] mem [0:(1<<AW)-1];
   int            resist = 0;
   logic [DW-1:0] stuck = '0;
   logic [AW-1:0] cur_a = '0;
   int            progs_seen = 0, reads_seen = 0, base_p = 0, base_r = 0;
   logic          m_busy = 1'b0, m_wr = 1'b0;
   int            lat = 0;
   logic [AW-1:0] m_addr = '0;
   logic [DW-1:0] m_wd = '0;

   always @(posedge clk) begin
      cdone <= 1'b0;
      if (!rst_n) begin
         m_busy <= 1'b0;
         for (int i = 0; i < (1<<AW); i++) mem[i] <= '0;
      end else if (m_busy) begin
         if (lat == 0) begin
            m_busy <= 1'b0;
            cdone  <= 1'b1;
            if (m_wr) begin
               chk((m_wd & mem[m_addr]) == '0, "R4", "program hits set bit", 64'(m_wd), 64'(m_wd & ~mem[m_addr]));
               if (progs_seen - base_p >= resist) mem[m_addr] <= mem[m_addr] | (m_wd & ~stuck);
               progs_seen <= progs_seen + 1;
            end else begin
               rdata      <= mem[m_addr];
               reads_seen <= reads_seen + 1;
            end
         end else begin
            chk(req && wr == m_wr && caddr == m_addr && wdata == m_wd, "R10", "command changed before done",
                64'({req, wr}), 64'({1'b1, m_wr}));
            lat <= lat - 1;
         end
      end else if (req && !cdone) begin
         chk(caddr == cur_a, "R2", "command address", 64'(caddr), 64'(cur_a));
         if (progs_seen == base_p && reads_seen == base_r)
            chk(!wr, "R2", "first command is a read", 64'(wr), 64'(0));
         m_busy <= 1'b1;
         lat    <= 1;
         m_wr   <= wr;
         m_addr <= caddr;
         m_wd   <= wdata;
      end
   end

   // Scoreboard
   typedef struct {
      logic          pass;
      int            progs;
      logic [AW-1:0] a;
      logic [DW-1:0] fin;
   } exp_t;
   exp_t q[$];
   logic done_prev = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (done_prev) begin
            chk(!done, "R8", "done longer than one cycle", 64'(done), 64'(0));
            chk(!busy, "R8", "busy after done", 64'(busy), 64'(0));
         end
         if (done) begin
            if (q.size() == 0) begin
               chk(1'b0, "R9", "unexpected completion", 64'(1), 64'(0));
            end else begin
               exp_t e;
               e = q.pop_front();
               chk(pass == e.pass, e.pass ? "R6" : "R7", "pass flag", 64'(pass), 64'(e.pass));
               chk(progs_seen - base_p == e.progs, "R3", "program commands",
                   64'(progs_seen - base_p), 64'(e.progs));
               chk(reads_seen - base_r == e.progs + 1, "R5", "read commands",
                   64'(reads_seen - base_r), 64'(e.progs + 1));
               chk(mem[e.a] == e.fin, "R6", "array word", 64'(mem[e.a]), 64'(e.fin));
            end
         end
         done_prev = done;
      end
   end

   task automatic run_op(input logic [AW-1:0] a, input logic [DW-1:0] v,
                         input int r, input logic [DW-1:0] s, input int intrude);
      exp_t          e;
      logic [DW-1:0] cur, need;
      @(negedge clk);
      while (busy) @(negedge clk);
      cur  = mem[a];
      need = v & ~cur;
      e.a  = a;
      if (need == '0) begin
         e.pass = 1'b1; e.progs = 0; e.fin = cur;
      end else begin
         e.pass  = ((need & s) == '0) && (r < 4);
         e.progs = e.pass ? r + 1 : 4;
         e.fin   = (r >= 4) ? cur : (cur | (need & ~s));
      end
      q.push_back(e);
      resist = r; stuck = s; cur_a = a;
      base_p = progs_seen; base_r = reads_seen;
      addr = a; value = v; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (intrude > 0) begin
         repeat (intrude) @(negedge clk);
         addr = 8'd10; value = 32'hFF; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy && !done && !req, "R1", "reset outputs", 64'({busy, done, req}), 64'(0));
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !req, "R1", "idle after reset", 64'({busy, req}), 64'(0));
      run_op(8'd5,  32'h0000_00F0, 0, '0, 0);        // R6 fresh burn
      run_op(8'd5,  32'h0000_00F0, 0, '0, 0);        // R3 nothing missing
      run_op(8'd5,  32'h0000_FFFF, 0, '0, 0);        // R4 partial word
      run_op(8'd6,  32'hA5A5_0001, 1, '0, 0);        // R5 one refused pulse
      run_op(8'd7,  32'h8000_0000, 3, '0, 0);        // R7 success on last attempt
      run_op(8'd8,  32'h1234_5678, 4, '0, 0);        // R7 budget exhausted
      run_op(8'd11, 32'h0000_00FF, 0, 32'h1, 0);     // R7 bit that never burns
      run_op(8'd9,  32'h0000_0F0F, 2, '0, 3);        // R9 start while busy
      chk(mem[10] == '0, "R9", "intruding address untouched", 64'(mem[10]), 64'(0));
      chk(!busy, "R9", "idle after intruded operation", 64'(busy), 64'(0));
      run_op(8'd0,  32'h0, 0, '0, 0);                // R3 empty request
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "R8", "watchdog expired", 64'(0), 64'(1));
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule